// File: doc/BRIEF.md
# Memory fault status capture unit

This block keeps a record of why memory-protection faults happened. Single-cycle event pulses from the processor core set sticky cause flags in an 8-bit status register. The possible events are an instruction-fetch violation, a data load/store violation, a stacking fault on exception entry, an unstacking fault on return, and a lazy floating-point preservation fault. Only a data violation comes with an address. That address is latched into a 32-bit fault address register, and an address-valid flag is raised next to it.

Software reaches both registers through a plain register port: a write strobe, a one-bit register select and write data, plus a combinational read bus. Cause flags are cleared by writing ones to them. A fault handler that takes over an escalated fault can drop the address-valid flag without touching any cause flag.

Top module: `mem_fault_status`

## Requirements
- R1: After reset the status register (select 0) and the fault address register (select 1) both read 0.
- R2: A data violation pulse sets status bit 1 and status bit 7 (address valid), and loads `ev_data_addr` into the address register. The change is visible on the read bus after the next rising clock edge.
- R3: An instruction-fetch violation pulse sets status bit 0. It leaves the address register and status bit 7 unchanged.
- R4: A stacking fault pulse sets status bit 4. It leaves the address register and bit 7 unchanged.
- R5: An unstacking fault pulse sets status bit 3. It leaves the address register and bit 7 unchanged.
- R6: With `HAS_FPU`=1, a lazy floating-point fault pulse sets status bit 5. With `HAS_FPU`=0, bit 5 always reads 0.
- R7: Cause flags are sticky. A status write clears each flag whose write-data bit is 1. Write-data bits that are 0 leave their flags unchanged.
- R8: A status write with bit 7 set clears the address-valid flag and leaves the cause flags and the address register as they were.
- R9: Status bits 2 and 6 always read 0, including after writes of ones to them. Read bits 31:8 of the status register are 0.
- R10: When a fault event and a software clear of the same bit occur in the same cycle, the bit ends up set.
- R11: A data violation that arrives while bit 7 is already set overwrites the address register with the newer address.
- R12: A write with select 1 loads the address register from write data and leaves the status register unchanged. A data violation in the same cycle takes precedence and its address is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ifetch | input | 1 | Instruction-fetch violation pulse |
| ev_data | input | 1 | Data access violation pulse |
| ev_data_addr | input | ADDR_W | Faulting address that comes with `ev_data` |
| ev_stack | input | 1 | Stacking fault pulse |
| ev_unstack | input | 1 | Unstacking fault pulse |
| ev_lazyfp | input | 1 | Lazy floating-point preservation fault pulse |
| reg_wr | input | 1 | Software write strobe |
| reg_sel | input | 1 | Register select: 0 = status, 1 = fault address |
| reg_wdata | input | ADDR_W | Software write data |
| reg_rdata | output | ADDR_W | Read data for the selected register |

## Verification
Every bit of internal state sits directly behind the read bus, so a wrong flag or address shows up on the first read after the faulty clock edge. A lost event, a flag that is not sticky, or a clear that hits the wrong bit is visible one cycle after the stimulus. A wrong priority between an event and a clear shows up only when both land in the same cycle, so the bench drives those collisions on purpose. An address register that wrongly captures on non-data faults is caught by reading the address back after each of those events.

// File: rtl/mem_fault_status.sv
module mem_fault_status #(
  parameter int ADDR_W  = 32,
  parameter bit HAS_FPU = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ifetch,
  input  logic              ev_data,
  input  logic [ADDR_W-1:0] ev_data_addr,
  input  logic              ev_stack,
  input  logic              ev_unstack,
  input  logic              ev_lazyfp,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata
);
  localparam logic [7:0] LIVE = HAS_FPU ? 8'hBB : 8'h9B;

  logic [7:0]        stat_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        set_v, clr_v;

  assign set_v = {ev_data, 1'b0, ev_lazyfp & HAS_FPU, ev_stack, ev_unstack,
                  1'b0, ev_data, ev_ifetch};
  assign clr_v = (reg_wr && !reg_sel) ? reg_wdata[7:0] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      addr_q <= '0;
    end else begin
      stat_q <= ((stat_q & ~clr_v) | set_v) & LIVE;
      if (ev_data)
        addr_q <= ev_data_addr;
      else if (reg_wr && reg_sel)
        addr_q <= reg_wdata;
    end
  end

  assign reg_rdata = reg_sel ? addr_q : {{(ADDR_W-8){1'b0}}, stat_q};

  p_data_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> (stat_q[1] && stat_q[7] && addr_q == $past(ev_data_addr)));

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_data && !(reg_wr && reg_sel)) |=> $stable(addr_q));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[0] && !(reg_wr && !reg_sel && reg_wdata[0])) |=> stat_q[0]);

  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[2] == 1'b0 && stat_q[6] == 1'b0));

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_unstack && reg_wr && !reg_sel && reg_wdata[3]) |=> stat_q[3]);

  p_valid_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata == 32'h80 && !ev_data) |=>
      (!stat_q[7] && stat_q[5:0] == $past(stat_q[5:0] | set_v[5:0])));

  generate
    if (!HAS_FPU) begin : g_nofp
      p_nofp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[5] == 1'b0);
    end
  endgenerate
endmodule

// File: tb/sim_mem_fault_status.sv
module sim_mem_fault_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_ifetch = 0, ev_data = 0, ev_stack = 0, ev_unstack = 0, ev_lazyfp = 0;
  logic [31:0] ev_data_addr = '0;
  logic        reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mem_fault_status u0 (
    .clk(clk), .rst_n(rst_n), .ev_ifetch(ev_ifetch), .ev_data(ev_data),
    .ev_data_addr(ev_data_addr), .ev_stack(ev_stack), .ev_unstack(ev_unstack),
    .ev_lazyfp(ev_lazyfp), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, hold through posedge, release at next negedge
  task automatic step(logic [4:0] ev, logic [31:0] ea, logic wr, logic sel, logic [31:0] wd);
    {ev_lazyfp, ev_stack, ev_unstack, ev_data, ev_ifetch} = ev;
    ev_data_addr = ea; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(negedge clk);
    {ev_lazyfp, ev_stack, ev_unstack, ev_data, ev_ifetch} = '0;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic sel, output logic [31:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic clear_all();
    step(5'b0, 0, 1, 0, 32'hFF);
    step(5'b0, 0, 1, 1, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 addr", v, 0);
  endtask

  task automatic t_causes();
    logic [31:0] v;
    clear_all();
    step(5'b00010, 32'h2000_0010, 0, 0, 0);
    rd(0, v); chk("R2 status", v, 32'h82);
    rd(1, v); chk("R2 addr", v, 32'h2000_0010);
    step(5'b0, 0, 1, 0, 32'h80);
    rd(0, v); chk("R8 valid cleared", v, 32'h02);
    rd(1, v); chk("R8 addr kept", v, 32'h2000_0010);
    step(5'b00001, 32'hDEAD_0000, 0, 0, 0);
    rd(0, v); chk("R3 status", v, 32'h03);
    rd(1, v); chk("R3 addr kept", v, 32'h2000_0010);
    step(5'b01000, 32'hDEAD_0004, 0, 0, 0);
    rd(0, v); chk("R4 status", v, 32'h13);
    rd(1, v); chk("R4 addr kept", v, 32'h2000_0010);
    step(5'b00100, 32'hDEAD_0008, 0, 0, 0);
    rd(0, v); chk("R5 status", v, 32'h1B);
    rd(1, v); chk("R5 addr kept", v, 32'h2000_0010);
    step(5'b10000, 32'hDEAD_000C, 0, 0, 0);
    rd(0, v); chk("R6 status", v, 32'h3B);
    rd(1, v); chk("R6 addr kept", v, 32'h2000_0010);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    step(5'b0, 0, 1, 0, 32'h00);
    rd(0, v); chk("R7 zero write", v, 32'h3B);
    step(5'b0, 0, 1, 0, 32'h01);
    rd(0, v); chk("R7 single clear", v, 32'h3A);
    step(5'b0, 0, 1, 0, 32'h18);
    rd(0, v); chk("R7 pair clear", v, 32'h22);
    step(5'b0, 0, 1, 0, 32'h22);
    rd(0, v); chk("R7 all clear", v, 32'h00);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    clear_all();
    step(5'b0, 0, 1, 0, 32'hFFFF_FF44);
    rd(0, v); chk("R9 rsvd write", v, 32'h00);
    step(5'b11111, 32'h55, 0, 0, 0);
    rd(0, v); chk("R9 all set", v, 32'hBB);
  endtask

  task automatic t_race();
    logic [31:0] v;
    clear_all();
    step(5'b00001, 0, 0, 0, 0);
    step(5'b00001, 0, 1, 0, 32'h01);
    rd(0, v); chk("R10 ifetch vs clear", v, 32'h01);
    step(5'b00100, 0, 1, 0, 32'h08);
    rd(0, v); chk("R10 unstack vs clear", v, 32'h09);
    step(5'b00010, 32'h0000_4444, 1, 0, 32'h82);
    rd(0, v); chk("R10 data vs clear", v, 32'h8B);
    rd(1, v); chk("R10 data addr", v, 32'h0000_4444);
  endtask

  task automatic t_overwrite();
    logic [31:0] v;
    clear_all();
    step(5'b00010, 32'hAAAA_0001, 0, 0, 0);
    step(5'b00010, 32'hBBBB_0002, 0, 0, 0);
    rd(1, v); chk("R11 newest addr", v, 32'hBBBB_0002);
    rd(0, v); chk("R11 status", v, 32'h82);
  endtask

  task automatic t_addr_write();
    logic [31:0] v;
    clear_all();
    step(5'b00001, 0, 0, 0, 0);
    step(5'b0, 0, 1, 1, 32'h0000_1234);
    rd(1, v); chk("R12 sw addr", v, 32'h0000_1234);
    rd(0, v); chk("R12 status kept", v, 32'h01);
    step(5'b00010, 32'hCAFE_0000, 1, 1, 32'h0000_5678);
    rd(1, v); chk("R12 event over write", v, 32'hCAFE_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_causes();
    t_w1c();
    t_reserved();
    t_race();
    t_overwrite();
    t_addr_write();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule